// File: doc/BRIEF.md
# Sub-warp merge pool

This block collects partial warps that appear after branch divergence and folds them into fuller issue groups. Each arriving entry carries a target program counter and a 32-bit lane mask. Each thread is tied to one physical SIMD lane. Two entries can therefore share an issue group only when they head for the same program counter and no lane is set in both masks.

Entries arrive on a valid/ready stream and are held in a small age-ordered pool, eight deep by default. A new entry is folded into the oldest compatible resident entry, or else it takes a free slot. The output stream presents one pool entry at a time. A resident entry whose mask has become completely full goes out first. Without a full entry, the oldest one goes out. Arrival and issue may occur in the same cycle.

Top module: `dwf_merge`

## Requirements
- R1: After reset the pool is empty: `out_valid` is 0 and `in_ready` is 1.
- R2: An offered entry whose mask is all zeros is accepted (`in_ready` 1) and dropped. It never reaches the output, and pool occupancy is unchanged.
- R3: An entry with the same PC as a resident entry and a mask disjoint from it is folded into that entry. The issued mask is the bitwise OR of the two masks.
- R4: An entry whose mask shares at least one lane with every resident entry of its PC takes a new slot. Both are issued separately, older first.
- R5: Entries with different PCs are never combined.
- R6: When several resident entries are compatible with an arrival, it is folded into the oldest of them.
- R7: With no all-ones mask in the pool, the output presents the oldest resident entry. `out_valid` stays high until that entry is taken.
- R8: A resident entry whose mask is all ones (0xFFFFFFFF) is issued ahead of older entries. Among several full entries, the oldest goes first.
- R9: With all slots occupied and no issue in that cycle, `in_ready` is 0 for an entry that matches no resident entry. It is 1 for one that fits a resident entry.
- R10: An arrival never folds into the entry being issued in the same cycle. It goes to another compatible entry or to a new slot. A slot freed by that issue may take the arrival in the same cycle.
- R11: An accepted entry in an empty pool appears on the output one cycle later with its PC and mask unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Arriving sub-warp valid |
| in_ready | output | 1 | Pool can take the arriving sub-warp |
| in_pc | input | 32 | Target PC of the arriving sub-warp |
| in_mask | input | 32 | Lane mask of the arriving sub-warp |
| out_valid | output | 1 | Issue group available |
| out_ready | input | 1 | Consumer takes the issue group |
| out_pc | output | 32 | PC of the issue group |
| out_mask | output | 32 | Lane mask of the issue group |

## Verification
A corrupted slot or a broken shift is visible at the ports in the next drain. It shows up as a wrong PC, a mask that is missing or duplicating lanes, or an issue order that breaks the age or full-first rule. The drain takes at most as many transfers as there are slots. A wrong occupancy count shows in the first cycle that `in_ready` is evaluated against a full pool. It also shows when a new entry lands in the wrong slot and comes out of order. A wrong fold decision with the same-cycle issue shows on the very next transfer as a mask with lanes added or missing.

// File: rtl/dwf_pkg.sv
package dwf_pkg;
  localparam int unsigned LANES = 32;
  localparam int unsigned PC_W  = 32;
  typedef logic [LANES-1:0] lane_mask_t;
  typedef logic [PC_W-1:0]  pc_t;
endpackage

// File: rtl/dwf_slot_match.sv
module dwf_slot_match
  import dwf_pkg::*;
(
  input  logic       slot_vld,
  input  pc_t        slot_pc,
  input  lane_mask_t slot_mask,
  input  logic       slot_busy,
  input  pc_t        arr_pc,
  input  lane_mask_t arr_mask,
  output logic       fits,
  output logic       is_full
);
  always_comb begin
    fits    = slot_vld && !slot_busy && (slot_pc == arr_pc) && ((slot_mask & arr_mask) == '0);
    is_full = slot_vld && (&slot_mask);
  end
endmodule

// File: rtl/dwf_first_pick.sv
module dwf_first_pick #(
  parameter int unsigned N   = 8,
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic [IW-1:0] idx,
  output logic          any
);
  always_comb begin
    idx = '0;
    any = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        idx = IW'(i);
        any = 1'b1;
      end
    end
  end
endmodule

// File: rtl/dwf_merge.sv
module dwf_merge
  import dwf_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [PC_W-1:0]  in_pc,
  input  logic [LANES-1:0] in_mask,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [PC_W-1:0]  out_pc,
  output logic [LANES-1:0] out_mask
);
  logic [DEPTH-1:0] vld_q, vld_n;
  pc_t              pc_q   [DEPTH];
  pc_t              pc_n   [DEPTH];
  lane_mask_t       mask_q [DEPTH];
  lane_mask_t       mask_n [DEPTH];

  logic [DEPTH-1:0] fit_vec, full_vec;
  logic [IW-1:0]    fit_idx, full_idx, sel_idx, tgt_idx, app_idx;
  logic             fit_any, full_any;
  logic             fire, accept, upd;
  logic [CW-1:0]    occ, occ_after;

  assign out_valid = vld_q[0];
  assign sel_idx   = full_any ? full_idx : '0;
  assign out_pc    = pc_q[sel_idx];
  assign out_mask  = mask_q[sel_idx];
  assign fire      = out_valid && out_ready;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    dwf_slot_match u_match (
      .slot_vld  (vld_q[g]),
      .slot_pc   (pc_q[g]),
      .slot_mask (mask_q[g]),
      .slot_busy (fire && (sel_idx == IW'(g))),
      .arr_pc    (in_pc),
      .arr_mask  (in_mask),
      .fits      (fit_vec[g]),
      .is_full   (full_vec[g])
    );
  end

  dwf_first_pick #(.N(DEPTH)) u_fit_pick (
    .req (fit_vec),
    .idx (fit_idx),
    .any (fit_any)
  );

  dwf_first_pick #(.N(DEPTH)) u_full_pick (
    .req (full_vec),
    .idx (full_idx),
    .any (full_any)
  );

  assign in_ready  = !(|in_mask) || fit_any || !vld_q[DEPTH-1] || fire;
  assign accept    = in_valid && in_ready && (|in_mask);
  assign occ       = CW'($countones(vld_q));
  assign occ_after = occ - CW'(fire);
  assign app_idx   = IW'(occ_after);
  assign tgt_idx   = (fire && (fit_idx > sel_idx)) ? fit_idx - IW'(1) : fit_idx;
  assign upd       = fire || accept;

  // next state: close the gap left by an issue, then place the arrival
  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      if (fire && (IW'(i) >= sel_idx)) begin
        if (i + 1 < DEPTH) begin
          vld_n[i]  = vld_q[(i + 1) % DEPTH];
          pc_n[i]   = pc_q[(i + 1) % DEPTH];
          mask_n[i] = mask_q[(i + 1) % DEPTH];
        end else begin
          vld_n[i]  = 1'b0;
          pc_n[i]   = pc_q[i];
          mask_n[i] = mask_q[i];
        end
      end else begin
        vld_n[i]  = vld_q[i];
        pc_n[i]   = pc_q[i];
        mask_n[i] = mask_q[i];
      end
    end
    if (accept) begin
      if (fit_any) begin
        mask_n[tgt_idx] = mask_n[tgt_idx] | in_mask;
      end else begin
        vld_n[app_idx]  = 1'b1;
        pc_n[app_idx]   = in_pc;
        mask_n[app_idx] = in_mask;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        pc_q[i]   <= '0;
        mask_q[i] <= '0;
      end
    end else if (upd) begin
      vld_q <= vld_n;
      for (int i = 0; i < DEPTH; i++) begin
        pc_q[i]   <= pc_n[i];
        mask_q[i] <= mask_n[i];
      end
    end
  end

  // R2: a zero-mask offer leaves occupancy untouched
  p_zero_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (in_mask == '0) && !fire) |=> (vld_q == $past(vld_q)));

  // R7: a presented group is held until taken
  p_hold_out_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid);

  // R9: a free slot always means the input can be taken
  p_ready_space_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !vld_q[DEPTH-1] |-> in_ready);

  // R11: first entry into an empty pool passes through unchanged
  p_fill_through_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !out_valid) |=> (out_valid && (out_pc == $past(in_pc)) && (out_mask == $past(in_mask))));

  // R2: nothing with an empty mask is ever presented
  p_no_empty_out_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_mask != '0));
endmodule

// File: tb/sim_dwf_merge.sv
module sim_dwf_merge;
  logic        clk;
  logic        rst_n;
  logic        in_valid, in_ready, out_valid, out_ready;
  logic [31:0] in_pc, in_mask, out_pc, out_mask;
  int          errors = 0;
  int          checks = 0;
  bit          done   = 0;

  dwf_merge u0 (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_pc(in_pc), .in_mask(in_mask),
    .out_valid(out_valid), .out_ready(out_ready), .out_pc(out_pc), .out_mask(out_mask)
  );

  initial clk = 0;
  always #4 clk = ~clk;

  // pushes {pc, mask} with the output stalled
  localparam logic [63:0] PUSH_V [7] = '{
    {32'd10, 32'h0000_000F},
    {32'd10, 32'h0000_00F0},   // R3 fold -> 0xFF
    {32'd10, 32'h0000_0003},   // R4 clash -> new slot
    {32'd20, 32'h0000_0100},   // R5 other PC -> new slot
    {32'd10, 32'h0000_0100},   // R6 oldest of two fits -> 0x1FF
    {32'd10, 32'h0000_0000},   // R2 dropped
    {32'd20, 32'hFFFF_FEFF}    // R3 fold -> full
  };
  localparam logic [63:0] DRAIN_V [3] = '{
    {32'd20, 32'hFFFF_FFFF},   // R8 full first
    {32'd10, 32'h0000_01FF},   // R6/R7
    {32'd10, 32'h0000_0003}    // R4
  };

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push(input logic [31:0] pc, input logic [31:0] m);
    in_valid = 1; in_pc = pc; in_mask = m;
    @(posedge clk); #1;
    in_valid = 0;
  endtask

  task automatic pop(input logic [31:0] pc, input logic [31:0] m, input string req);
    out_ready = 1; #1;
    chk(out_valid && out_pc == pc && out_mask == m, req, {out_pc, out_mask}, {pc, m});
    @(posedge clk); #1;
    out_ready = 0;
  endtask

  task automatic do_reset();
    rst_n = 0; in_valid = 0; out_ready = 0; in_pc = 0; in_mask = 0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1;
    @(posedge clk); #1;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    do_reset();
    chk(!out_valid && in_ready, "R1", {62'd0, out_valid, in_ready}, 64'd1);

    // table walk
    for (int i = 0; i < 7; i++) begin
      push(PUSH_V[i][63:32], PUSH_V[i][31:0]);
      if (i == 0)
        chk(out_valid && out_mask == 32'hF, "R11", {out_pc, out_mask}, {32'd10, 32'hF});
    end
    for (int i = 0; i < 3; i++) pop(DRAIN_V[i][63:32], DRAIN_V[i][31:0], "R3-R8 drain");
    #1 chk(!out_valid, "R2", {63'd0, out_valid}, 64'd0);

    // R9 full pool
    for (int i = 0; i < 8; i++) push(32'(i + 1), 32'h1);
    in_valid = 1; in_pc = 99; in_mask = 32'h1; #1;
    chk(!in_ready, "R9", {63'd0, in_ready}, 64'd0);
    in_pc = 1; in_mask = 32'h2; #1;
    chk(in_ready, "R9", {63'd0, in_ready}, 64'd1);
    in_valid = 0;
    push(32'd1, 32'h2);
    in_valid = 1; in_pc = 77; in_mask = 32'h1; out_ready = 1; #1;
    chk(in_ready, "R10", {63'd0, in_ready}, 64'd1);
    chk(out_pc == 1 && out_mask == 32'h3, "R3", {out_pc, out_mask}, {32'd1, 32'h3});
    @(posedge clk); #1;
    in_valid = 0; out_ready = 0;
    for (int i = 2; i <= 8; i++) pop(32'(i), 32'h1, "R7");
    pop(32'd77, 32'h1, "R10");

    // R10 arrival beside a same-cycle issue of its only partner
    push(32'd5, 32'h1);
    in_valid = 1; in_pc = 5; in_mask = 32'h2; out_ready = 1; #1;
    chk(out_mask == 32'h1, "R10", {32'd0, out_mask}, {32'd0, 32'h1});
    @(posedge clk); #1;
    in_valid = 0; out_ready = 0;
    pop(32'd5, 32'h2, "R10");
    #1 chk(!out_valid, "R10", {63'd0, out_valid}, 64'd0);

    // R5/R4 ordering, R2 at the ports
    in_valid = 1; in_pc = 3; in_mask = 0; #1;
    chk(in_ready, "R2", {63'd0, in_ready}, 64'd1);
    @(posedge clk); #1 in_valid = 0;
    chk(!out_valid, "R2", {63'd0, out_valid}, 64'd0);
    push(32'd6, 32'h10);
    push(32'd7, 32'h20);
    push(32'd6, 32'h10);
    pop(32'd6, 32'h10, "R5");
    pop(32'd7, 32'h20, "R5");
    pop(32'd6, 32'h10, "R4");

    do_reset();
    chk(!out_valid && in_ready, "R1", {62'd0, out_valid, in_ready}, 64'd1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule